// File: doc/BRIEF.md
# Prioritized Exception Cause Selector

The selector sits between the cause-detection logic of a small embedded core and its exception sequencer. Each cycle it looks at one request line per priority level and applies several gates. One enable covers the whole critical class and one covers the whole noncritical class. Debug levels count only while internal debug mode is on, and a few levels have an enable of their own. Among the requests that survive, the lowest level number wins. The ordering is a fixed fifteen-level ladder in which critical and noncritical causes are interleaved. Causes that are mutually exclusive within one instruction share a level, so no tie-break is needed.

The winner's level number and its class flag are registered. A valid flag and a one-cycle dispatch pulse go with them. Once a winner is presented, it stays frozen until the core raises the acknowledge input. Only then are requests sampled again, which means a level-sensitive cause that is still active wins again straight away.

Top module: `exc_cause_picker`

## Requirements
- R1: An active-low synchronous reset (rst_n low at a clock edge) clears valid, dispatch, code and crit to 0.
- R2: Request bit L-1 of cause_req stands for priority level L (1 to 15). Among the eligible requests, the lowest level number wins and is reported as code = L.
- R3: crit is 1 when the winner is level 1, 2, 3, 4, 5, 6 or 15, and 0 when it is level 7 to 14.
- R4: With crit_en low, levels 1 to 6 and 15 are never eligible, and a pending noncritical level wins instead.
- R5: With ncrit_en low, levels 7 to 14 are never eligible.
- R6: Levels 2, 4 and 15 (debug) are eligible only while dbg_mode is high.
- R7: cause_en bit L-1 gates levels 5, 6 and 14 one by one. For every other level, cause_en has no effect.
- R8: A winner is loaded on the clock edge that samples its request, so valid, code and crit show it one cycle after the request is applied. valid is 1 only when some request was eligible at that edge.
- R9: While valid is 1 and ack is 0, code and crit hold their value, whatever happens on the requests.
- R10: dispatch is high for exactly one cycle each time a winner is loaded, including a reload on the edge that samples ack.
- R11: If ack is sampled while nothing is eligible, the next cycle shows valid = 0, code = 0 and crit = 0.
- R12: A request that is still held when ack is sampled is selected again. This is how level-sensitive causes behave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cause_req | input | LEVELS | One request per priority level, bit L-1 = level L |
| cause_en | input | LEVELS | Per-level enables, used only for maskable levels |
| crit_en | input | 1 | Critical class enable |
| ncrit_en | input | 1 | Noncritical class enable |
| dbg_mode | input | 1 | Internal debug mode, qualifies debug levels |
| ack | input | 1 | Core has taken the presented winner |
| valid | output | 1 | A winner is being presented |
| dispatch | output | 1 | One-cycle pulse when a winner is loaded |
| code | output | CODE_W | Winning level number, 0 when idle |
| crit | output | 1 | Winner belongs to the critical class |

## Verification
The bench builds the selector with its default parameters: fifteen levels, critical map 0x403F, debug map 0x400A and maskable map 0x2030. With these values every rung of the ladder can be reached, including the interleaving where critical level 15 lies below all the noncritical levels. All three individually maskable levels can also be reached. The table vectors keep ack high so that every vector is a fresh selection. Directed sequences then hold ack low to exercise freezing, reload after acknowledge and the idle return.

// File: rtl/exc_cause_picker.sv
module exc_cause_picker #(
  parameter int LEVELS = 15,
  parameter int CODE_W = $clog2(LEVELS + 1),
  parameter logic [LEVELS-1:0] CRIT_MAP = 15'h403F,
  parameter logic [LEVELS-1:0] DBG_MAP  = 15'h400A,
  parameter logic [LEVELS-1:0] MASKABLE = 15'h2030
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] cause_req,
  input  logic [LEVELS-1:0] cause_en,
  input  logic              crit_en,
  input  logic              ncrit_en,
  input  logic              dbg_mode,
  input  logic              ack,
  output logic              valid,
  output logic              dispatch,
  output logic [CODE_W-1:0] code,
  output logic              crit
);

  logic [LEVELS-1:0] class_ok, dbg_ok, own_ok, eligible;
  logic [CODE_W-1:0] win_code;
  logic              win_crit;
  logic              take;

  assign class_ok = (CRIT_MAP & {LEVELS{crit_en}}) | (~CRIT_MAP & {LEVELS{ncrit_en}});
  assign dbg_ok   = ~DBG_MAP | {LEVELS{dbg_mode}};
  assign own_ok   = ~MASKABLE | cause_en;
  assign eligible = cause_req & class_ok & dbg_ok & own_ok;
  assign take     = !valid || ack;

  always_comb begin
    win_code = '0;
    win_crit = 1'b0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        win_code = CODE_W'(i + 1);
        win_crit = CRIT_MAP[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      dispatch <= 1'b0;
      code     <= '0;
      crit     <= 1'b0;
    end else begin
      dispatch <= 1'b0;
      if (take) begin
        valid    <= |eligible;
        dispatch <= |eligible;
        code     <= win_code;
        crit     <= win_crit;
      end
    end
  end

endmodule

// File: rtl/exc_cause_picker_chk.sv
module exc_cause_picker_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              crit_en,
  input logic              ncrit_en,
  input logic              ack,
  input logic              valid,
  input logic              dispatch,
  input logic [CODE_W-1:0] code,
  input logic              crit
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !valid && !dispatch); // R1
  AST_HOLD_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ack |=> valid && $stable(code) && $stable(crit)); // R9
  AST_PULSE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> valid); // R10
  AST_NO_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ack |=> !dispatch); // R10
  AST_CRIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch && crit |-> $past(crit_en)); // R4
  AST_NCRIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch && !crit |-> $past(ncrit_en)); // R5
  AST_CODE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> code != '0); // R2
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> code == '0 && !crit); // R11

endmodule

bind exc_cause_picker exc_cause_picker_chk #(.CODE_W(CODE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .crit_en(crit_en), .ncrit_en(ncrit_en), .ack(ack),
  .valid(valid), .dispatch(dispatch), .code(code), .crit(crit)
);

// File: tb/test_exc_cause_picker.sv
module test_exc_cause_picker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] cause_req = '0;
  logic [14:0] cause_en = '1;
  logic        crit_en = 1'b1, ncrit_en = 1'b1, dbg_mode = 1'b1, ack = 1'b0;
  logic        valid, dispatch, crit;
  logic [3:0]  code;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  exc_cause_picker i_exc_cause_picker (
    .clk(clk), .rst_n(rst_n), .cause_req(cause_req), .cause_en(cause_en),
    .crit_en(crit_en), .ncrit_en(ncrit_en), .dbg_mode(dbg_mode), .ack(ack),
    .valid(valid), .dispatch(dispatch), .code(code), .crit(crit)
  );

  // req, {crit_en,ncrit_en,dbg_mode}, cause_en, exp valid, exp code, exp crit
  localparam int NV = 17;
  localparam logic [38:0] VEC [NV] = '{
    {15'h7FFF, 3'b111, 15'h7FFF, 1'b1, 4'd1,  1'b1},  // R2 R3
    {15'h7FFE, 3'b111, 15'h7FFF, 1'b1, 4'd2,  1'b1},  // R2
    {15'h7FFF, 3'b011, 15'h7FFF, 1'b1, 4'd7,  1'b0},  // R4
    {15'h7FFF, 3'b101, 15'h7FFF, 1'b1, 4'd1,  1'b1},  // R5
    {15'h4040, 3'b011, 15'h7FFF, 1'b1, 4'd7,  1'b0},  // R4
    {15'h4000, 3'b111, 15'h7FFF, 1'b1, 4'd15, 1'b1},  // R3 R6
    {15'h4000, 3'b110, 15'h7FFF, 1'b0, 4'd0,  1'b0},  // R6
    {15'h008A, 3'b110, 15'h7FFF, 1'b1, 4'd8,  1'b0},  // R6
    {15'h0010, 3'b111, 15'h7FEF, 1'b0, 4'd0,  1'b0},  // R7
    {15'h0030, 3'b111, 15'h7FEF, 1'b1, 4'd6,  1'b1},  // R7
    {15'h2000, 3'b111, 15'h5FFF, 1'b0, 4'd0,  1'b0},  // R7
    {15'h0040, 3'b111, 15'h0000, 1'b1, 4'd7,  1'b0},  // R7
    {15'h2200, 3'b111, 15'h7FFF, 1'b1, 4'd10, 1'b0},  // R2
    {15'h1000, 3'b111, 15'h7FFF, 1'b1, 4'd13, 1'b0},  // R3
    {15'h0000, 3'b111, 15'h7FFF, 1'b0, 4'd0,  1'b0},  // R8
    {15'h0004, 3'b110, 15'h7FFF, 1'b1, 4'd3,  1'b1},  // R3
    {15'h1800, 3'b111, 15'h7FFF, 1'b1, 4'd12, 1'b0}   // R2
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 valid", valid, 0); chk("R1 dispatch", dispatch, 0);
    chk("R1 code", code, 0);   chk("R1 crit", crit, 0);
    rst_n = 1'b1;

    ack = 1'b1;
    for (int i = 0; i < NV; i++) begin
      cause_req = VEC[i][38:24];
      {crit_en, ncrit_en, dbg_mode} = VEC[i][23:21];
      cause_en = VEC[i][20:6];
      step();
      chk($sformatf("R2 vec%0d valid", i), valid, VEC[i][5]);
      chk($sformatf("R2 vec%0d code", i), code, VEC[i][4:1]);
      chk($sformatf("R3 vec%0d crit", i), crit, VEC[i][0]);
      chk($sformatf("R10 vec%0d dispatch", i), dispatch, VEC[i][5]);
    end

    // return to idle with ack high and no request
    cause_req = '0; crit_en = 1; ncrit_en = 1; dbg_mode = 1; cause_en = '1;
    step();
    chk("R11 idle valid", valid, 0);

    // R8 latency and R10 pulse
    ack = 1'b0;
    cause_req = 15'h0100;
    step();
    chk("R8 valid", valid, 1); chk("R8 code", code, 9);
    chk("R10 pulse", dispatch, 1);
    step();
    chk("R10 pulse single", dispatch, 0); chk("R9 valid held", valid, 1);

    // R9 hold against higher priority and withdrawn requests
    cause_req = 15'h0001;
    step();
    chk("R9 code held", code, 9); chk("R9 crit held", crit, 0);
    cause_req = '0;
    step();
    chk("R9 code held idle req", code, 9); chk("R9 valid held idle req", valid, 1);

    // R11 ack with nothing eligible
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R11 valid", valid, 0); chk("R11 code", code, 0); chk("R11 crit", crit, 0);

    // R12 level-sensitive reselection
    cause_req = 15'h0010;
    step();
    chk("R12 first code", code, 5); chk("R12 first pulse", dispatch, 1);
    step();
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R12 reload code", code, 5); chk("R12 reload pulse", dispatch, 1);
    chk("R12 reload crit", crit, 1);

    // R1 reset while presenting
    rst_n = 1'b0;
    step();
    chk("R1 midrun valid", valid, 0); chk("R1 midrun code", code, 0);
    rst_n = 1'b1;
    cause_req = '0;
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule